// File: doc/BRIEF.md
# ATA PIO Timing Engine

This block runs programmed-I/O cycles to one external ATA/IDE drive. A host-side request names a 3-bit drive register address, which of the two chip selects to use, the direction, whether the access targets the 16-bit data port or an 8-bit drive register, and the write data. The engine then produces the drive-side waveform: address and chip select, then the read or write strobe, then a hold, then a recovery gap. Every phase length is a count of system clock cycles taken from configuration inputs. Software sets those counts to reach PIO modes 0 through 4 at the clock rate in use.

While the strobe is active, a low ready line from the drive holds the strobe past its programmed width. A separate limit caps that wait. If the limit is reached, the strobe is released anyway and the access is marked as timed out. Read data is captured when the strobe ends. Drive-register accesses keep only the low byte. The drive interrupt and a drive reset request each pass through one register stage.

Top module: `pio_xfer_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both chip selects, both strobes and `dev_doe` are inactive (chip selects and strobes high, `dev_doe` low), `busy` is low, and `dev_reset_n` is low.
- R2: A request is accepted only when `req_valid` is high and `busy` is low. A request presented while `busy` is high is dropped: the drive address does not change and no second strobe follows.
- R3: The selected chip select and the drive address are active for exactly T1 cycles before the strobe falls, and a strobe is never low without a chip select.
- R4: With the drive ready, the strobe stays low for exactly T2 cycles.
- R5: The chip select stays active for exactly T3 cycles after the strobe rises, then goes inactive.
- R6: `busy` rises on the edge that accepts a request and stays high for T1+T2+T3+T4 cycles, plus any ready wait.
- R7: The drive is ready when `dev_ready` is high. If `dev_ready` is low when the T2 count ends, the strobe is held low. It is released on the cycle after ready is first sampled high.
- R8: If ready stays low, the strobe is released after T2+TMO cycles in total and `rsp_timeout` is 1 for that access. The next access that completes normally reports 0.
- R9: `rsp_valid` pulses for one cycle when the strobe rises. On a read, `rsp_rdata` holds `dev_din` as sampled on that edge. When `req_is_data` is 0, bits 15:8 of both `rsp_rdata` and `dev_dout` are zero.
- R10: A write drives `dev_dout` with `dev_doe` high from chip-select assertion to release and uses `dev_wr_n` only. A read uses `dev_rd_n` only, with `dev_doe` low. `req_cs_sel`=0 selects `dev_cs0_n` and 1 selects `dev_cs1_n`. At most one chip select and one strobe are low at once.
- R11: A phase count of 0 acts as 1 cycle.
- R12: `irq_out` follows `dev_intrq` and `dev_reset_n` follows the inverse of `dev_reset_req`, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_t1 | input | CNT_W | Setup cycles before strobe |
| cfg_t2 | input | CNT_W | Minimum strobe width in cycles |
| cfg_t3 | input | CNT_W | Hold cycles after strobe |
| cfg_t4 | input | CNT_W | Recovery cycles before next access |
| cfg_tmo | input | TMO_W | Extra wait cycles allowed for ready |
| req_valid | input | 1 | Access request |
| req_addr | input | 3 | Drive register address |
| req_cs_sel | input | 1 | 0: chip select 0, 1: chip select 1 |
| req_wr | input | 1 | 1: write, 0: read |
| req_is_data | input | 1 | 1: 16-bit data port, 0: 8-bit register |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| rsp_timeout | output | 1 | Last access hit the ready limit |
| dev_addr | output | 3 | Drive register address |
| dev_cs0_n | output | 1 | Chip select 0, active low |
| dev_cs1_n | output | 1 | Chip select 1, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Write data to drive |
| dev_doe | output | 1 | Output enable for `dev_dout` |
| dev_din | input | 16 | Read data from drive |
| dev_ready | input | 1 | Drive ready |
| dev_intrq | input | 1 | Drive interrupt |
| irq_out | output | 1 | Registered drive interrupt |
| dev_reset_req | input | 1 | Request to reset the drive |
| dev_reset_n | output | 1 | Drive reset, active low |

## Verification
The hardest cases to reach from the ports are the ready wait and its timeout. `dev_ready` must be low at exactly the edge where the T2 count runs out, and it must go high at a chosen point inside the stretched strobe. The bench drives `dev_ready` from a model that counts how long the strobe pin has been low. Ready rises only after a set number of low cycles, so the stretch length and the timeout threshold can each be placed cycle-exactly. A second hard case is a request that arrives mid-access. The bench injects it while `busy` is high and then confirms that the address held on the pins and the single completion pulse are unchanged.

// File: rtl/pio_xfer_pkg.sv
package pio_xfer_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int WORD_W     = 16;
  localparam int REG_BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } phase_e;

  typedef struct packed {
    logic [REG_ADDR_W-1:0] addr;
    logic                  cs_sel;
    logic                  wr;
    logic                  is_data;
    logic [WORD_W-1:0]     wdata;
  } xfer_t;
endpackage

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_xfer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_t1,
  input  logic [CNT_W-1:0] cfg_t2,
  input  logic [CNT_W-1:0] cfg_t3,
  input  logic [CNT_W-1:0] cfg_t4,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             req_valid,
  input  xfer_t            req,
  input  logic             dev_ready,
  output phase_e           phase,
  output xfer_t            cur,
  output logic             timed_out,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] wcnt;

  // a zero count behaves as a single cycle
  function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - CNT_W'(1);
  endfunction

  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      wcnt      <= '0;
      cur       <= '0;
      timed_out <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase     <= PH_SETUP;
            cnt       <= load_of(cfg_t1);
            cur       <= req;
            timed_out <= 1'b0;
            wcnt      <= '0;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= load_of(cfg_t2);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (dev_ready) begin
            phase <= PH_HOLD;
            cnt   <= load_of(cfg_t3);
          end else if (wcnt == cfg_tmo) begin
            phase     <= PH_HOLD;
            cnt       <= load_of(cfg_t3);
            timed_out <= 1'b1;
          end else begin
            wcnt <= wcnt + TMO_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            phase <= PH_RECOV;
            cnt   <= load_of(cfg_t4);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_RECOV: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (phase == PH_SETUP)) else $error("accept failed"); // R2

  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cur)) else $error("request replaced while busy"); // R2

endmodule

// File: rtl/pio_pin_drv.sv
module pio_pin_drv
  import pio_xfer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  phase_e                phase,
  input  xfer_t                 cur,
  input  logic                  timed_out,
  input  logic [WORD_W-1:0]     dev_din,
  input  logic                  dev_intrq,
  input  logic                  dev_reset_req,
  output logic [REG_ADDR_W-1:0] dev_addr,
  output logic                  dev_cs0_n,
  output logic                  dev_cs1_n,
  output logic                  dev_rd_n,
  output logic                  dev_wr_n,
  output logic [WORD_W-1:0]     dev_dout,
  output logic                  dev_doe,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_rdata,
  output logic                  rsp_timeout,
  output logic                  irq_out,
  output logic                  dev_reset_n
);

  localparam logic [WORD_W-1:0] BYTE_MASK =
    {{(WORD_W-REG_BYTE_W){1'b0}}, {REG_BYTE_W{1'b1}}};

  logic              sel_on;
  logic              stb_on;
  logic              stb_q;
  logic              release_edge;
  logic [WORD_W-1:0] lane_mask;

  assign sel_on       = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign stb_on       = (phase == PH_STROBE);
  assign release_edge = stb_q && !stb_on;
  assign lane_mask    = cur.is_data ? '1 : BYTE_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_addr    <= '0;
      dev_cs0_n   <= 1'b1;
      dev_cs1_n   <= 1'b1;
      dev_rd_n    <= 1'b1;
      dev_wr_n    <= 1'b1;
      dev_dout    <= '0;
      dev_doe     <= 1'b0;
      stb_q       <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
      irq_out     <= 1'b0;
      dev_reset_n <= 1'b0;
    end else begin
      dev_addr    <= cur.addr;
      dev_cs0_n   <= !(sel_on && !cur.cs_sel);
      dev_cs1_n   <= !(sel_on && cur.cs_sel);
      dev_rd_n    <= !(stb_on && !cur.wr);
      dev_wr_n    <= !(stb_on && cur.wr);
      dev_dout    <= cur.wdata & lane_mask;
      dev_doe     <= sel_on && cur.wr;
      stb_q       <= stb_on;
      rsp_valid   <= release_edge;
      if (release_edge) begin
        rsp_timeout <= timed_out;
        if (!cur.wr) rsp_rdata <= dev_din & lane_mask;
      end
      irq_out     <= dev_intrq;
      dev_reset_n <= !dev_reset_req;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!dev_rd_n && !dev_wr_n)) else $error("both strobes low"); // R10

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!dev_cs0_n, !dev_cs1_n})) else $error("both selects low"); // R10

  AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!dev_rd_n || !dev_wr_n) |-> (!dev_cs0_n || !dev_cs1_n)) else $error("strobe without select"); // R3

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !(dev_doe && !dev_rd_n)) else $error("driving during read"); // R10

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((!dev_cs0_n || !dev_cs1_n) && $past(!dev_cs0_n || !dev_cs1_n)) |-> $stable(dev_addr))
    else $error("address moved under select"); // R2

endmodule

// File: rtl/pio_xfer_engine.sv
module pio_xfer_engine
  import pio_xfer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMO_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      cfg_t1,
  input  logic [CNT_W-1:0]      cfg_t2,
  input  logic [CNT_W-1:0]      cfg_t3,
  input  logic [CNT_W-1:0]      cfg_t4,
  input  logic [TMO_W-1:0]      cfg_tmo,
  input  logic                  req_valid,
  input  logic [REG_ADDR_W-1:0] req_addr,
  input  logic                  req_cs_sel,
  input  logic                  req_wr,
  input  logic                  req_is_data,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_rdata,
  output logic                  rsp_timeout,
  output logic [REG_ADDR_W-1:0] dev_addr,
  output logic                  dev_cs0_n,
  output logic                  dev_cs1_n,
  output logic                  dev_rd_n,
  output logic                  dev_wr_n,
  output logic [WORD_W-1:0]     dev_dout,
  output logic                  dev_doe,
  input  logic [WORD_W-1:0]     dev_din,
  input  logic                  dev_ready,
  input  logic                  dev_intrq,
  output logic                  irq_out,
  input  logic                  dev_reset_req,
  output logic                  dev_reset_n
);

  xfer_t  req_bundle;
  xfer_t  cur;
  phase_e phase;
  logic   timed_out;

  assign req_bundle = '{addr: req_addr, cs_sel: req_cs_sel, wr: req_wr,
                        is_data: req_is_data, wdata: req_wdata};

  pio_phase_seq #(.CNT_W(CNT_W), .TMO_W(TMO_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_t1    (cfg_t1),
    .cfg_t2    (cfg_t2),
    .cfg_t3    (cfg_t3),
    .cfg_t4    (cfg_t4),
    .cfg_tmo   (cfg_tmo),
    .req_valid (req_valid),
    .req       (req_bundle),
    .dev_ready (dev_ready),
    .phase     (phase),
    .cur       (cur),
    .timed_out (timed_out),
    .busy      (busy)
  );

  pio_pin_drv pins_i (
    .clk           (clk),
    .rst           (rst),
    .phase         (phase),
    .cur           (cur),
    .timed_out     (timed_out),
    .dev_din       (dev_din),
    .dev_intrq     (dev_intrq),
    .dev_reset_req (dev_reset_req),
    .dev_addr      (dev_addr),
    .dev_cs0_n     (dev_cs0_n),
    .dev_cs1_n     (dev_cs1_n),
    .dev_rd_n      (dev_rd_n),
    .dev_wr_n      (dev_wr_n),
    .dev_dout      (dev_dout),
    .dev_doe       (dev_doe),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_timeout   (rsp_timeout),
    .irq_out       (irq_out),
    .dev_reset_n   (dev_reset_n)
  );

endmodule

// File: tb/pio_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module pio_xfer_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_t1 = 8'd2, cfg_t2 = 8'd3, cfg_t3 = 8'd2, cfg_t4 = 8'd4;
  logic [7:0]  cfg_tmo = 8'd5;
  logic        req_valid = 1'b0;
  logic [2:0]  req_addr = '0;
  logic        req_cs_sel = 1'b0, req_wr = 1'b0, req_is_data = 1'b1;
  logic [15:0] req_wdata = '0;
  logic        busy, rsp_valid, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic [2:0]  dev_addr;
  logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_doe;
  logic [15:0] dev_dout;
  logic [15:0] dev_din = '0;
  logic        dev_ready = 1'b1;
  logic        dev_intrq = 1'b0, irq_out;
  logic        dev_reset_req = 1'b0, dev_reset_n;

  int chk_n = 0;
  int fail_n = 0;

  // monitor counters
  int pre_n, stb_n, post_n, busy_n, done_n, addr_bad, cs0_n_cnt, cs1_n_cnt;
  int doe_n, dout_bad, rd_n_cnt, wr_n_cnt, stb_run, rdy_lat;
  bit seen_stb;
  logic [2:0]  exp_addr;
  logic [15:0] exp_dout;

  always #2.5 clk = ~clk;

  pio_xfer_engine dut_i (
    .clk(clk), .rst(rst),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_t3(cfg_t3), .cfg_t4(cfg_t4), .cfg_tmo(cfg_tmo),
    .req_valid(req_valid), .req_addr(req_addr), .req_cs_sel(req_cs_sel), .req_wr(req_wr),
    .req_is_data(req_is_data), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .dev_addr(dev_addr), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_dout(dev_dout), .dev_doe(dev_doe),
    .dev_din(dev_din), .dev_ready(dev_ready), .dev_intrq(dev_intrq), .irq_out(irq_out),
    .dev_reset_req(dev_reset_req), .dev_reset_n(dev_reset_n)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // pin monitor and ready model, both at the falling edge
  always @(negedge clk) begin
    logic stb, csl;
    stb = !dev_rd_n || !dev_wr_n;
    csl = !dev_cs0_n || !dev_cs1_n;
    if (csl && !stb && !seen_stb) pre_n++;
    if (stb) begin stb_n++; seen_stb = 1'b1; end
    if (csl && !stb && seen_stb) post_n++;
    if (busy) busy_n++;
    if (rsp_valid) done_n++;
    if (csl && dev_addr != exp_addr) addr_bad++;
    if (!dev_cs0_n) cs0_n_cnt++;
    if (!dev_cs1_n) cs1_n_cnt++;
    if (!dev_rd_n) rd_n_cnt++;
    if (!dev_wr_n) wr_n_cnt++;
    if (dev_doe) begin
      doe_n++;
      if (dev_dout != exp_dout) dout_bad++;
    end
    stb_run   = stb ? stb_run + 1 : 0;
    dev_ready = (stb_run >= rdy_lat);
  end

  task automatic clear_mon();
    pre_n = 0; stb_n = 0; post_n = 0; busy_n = 0; done_n = 0; addr_bad = 0;
    cs0_n_cnt = 0; cs1_n_cnt = 0; doe_n = 0; dout_bad = 0; rd_n_cnt = 0; wr_n_cnt = 0;
    seen_stb = 1'b0;
  endtask

  task automatic present(input logic [2:0] a, input logic cs, input logic wr,
                         input logic isd, input logic [15:0] wd);
    @(negedge clk);
    clear_mon();
    exp_addr    = a;
    exp_dout    = isd ? wd : {8'h00, wd[7:0]};
    req_addr    = a; req_cs_sel = cs; req_wr = wr; req_is_data = isd; req_wdata = wd;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  task automatic finish_access();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_eq("R1 cs0_n in reset", dev_cs0_n, 1);
    check_eq("R1 cs1_n in reset", dev_cs1_n, 1);
    check_eq("R1 strobes in reset", {dev_rd_n, dev_wr_n}, 3);
    check_eq("R1 doe/busy in reset", {dev_doe, busy}, 0);
    check_eq("R1 dev_reset_n in reset", dev_reset_n, 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 idle after reset", {busy, dev_doe, dev_rd_n, dev_wr_n}, 4'b0011);
    check_eq("R12 dev_reset_n released", dev_reset_n, 1);
  endtask

  task automatic t_write_data();
    cfg_t1 = 2; cfg_t2 = 3; cfg_t3 = 2; cfg_t4 = 4;
    present(3'd0, 1'b0, 1'b1, 1'b1, 16'hA5C3);
    finish_access();
    check_eq("R3 setup cycles", pre_n, 2);
    check_eq("R4 strobe width", stb_n, 3);
    check_eq("R5 hold cycles", post_n, 2);
    check_eq("R6 busy cycles", busy_n, 11);
    check_eq("R10 write strobe only", wr_n_cnt * 100 + rd_n_cnt, 300);
    check_eq("R10 doe window", doe_n, 7);
    check_eq("R10 dout value", dout_bad, 0);
    check_eq("R10 cs0 selected", cs0_n_cnt * 100 + cs1_n_cnt, 700);
    check_eq("R9 one completion", done_n, 1);
  endtask

  task automatic t_read_data();
    dev_din = 16'hBEEF;
    present(3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    finish_access();
    check_eq("R9 data read", rsp_rdata, 16'hBEEF);
    check_eq("R10 read strobe only", rd_n_cnt * 100 + wr_n_cnt, 300);
    check_eq("R10 no doe on read", doe_n, 0);
  endtask

  task automatic t_reg_read();
    dev_din = 16'h12F7;
    present(3'd7, 1'b1, 1'b0, 1'b0, 16'h0);
    finish_access();
    check_eq("R9 register read masked", rsp_rdata, 16'h00F7);
    check_eq("R10 cs1 selected", cs1_n_cnt * 100 + cs0_n_cnt, 700);
    check_eq("R3 address on pins", addr_bad, 0);
  endtask

  task automatic t_reg_write();
    present(3'd5, 1'b1, 1'b1, 1'b0, 16'hABCD);
    finish_access();
    check_eq("R9 register write masked", dout_bad, 0);
    check_eq("R9 register write doe", doe_n, 7);
    check_eq("R9 dout low byte", dev_dout, 16'h00CD);
  endtask

  task automatic t_stretch();
    rdy_lat = 5;
    present(3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    finish_access();
    rdy_lat = 0;
    check_eq("R7 stretched strobe", stb_n, 6);
    check_eq("R7 busy with wait", busy_n, 14);
    check_eq("R7 no timeout", rsp_timeout, 0);
  endtask

  task automatic t_timeout();
    cfg_tmo = 4;
    rdy_lat = 1000;
    present(3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    finish_access();
    rdy_lat = 0;
    check_eq("R8 strobe capped", stb_n, 7);
    check_eq("R8 timeout flagged", rsp_timeout, 1);
    check_eq("R8 completion", done_n, 1);
    present(3'd1, 1'b0, 1'b0, 1'b1, 16'h0);
    finish_access();
    check_eq("R8 flag cleared", rsp_timeout, 0);
  endtask

  task automatic t_zero_counts();
    cfg_t1 = 0; cfg_t2 = 0; cfg_t3 = 0; cfg_t4 = 0;
    present(3'd2, 1'b0, 1'b1, 1'b1, 16'h1234);
    finish_access();
    check_eq("R11 zero setup", pre_n, 1);
    check_eq("R11 zero strobe", stb_n, 1);
    check_eq("R11 zero hold", post_n, 1);
    check_eq("R11 zero busy", busy_n, 4);
    cfg_t1 = 2; cfg_t2 = 3; cfg_t3 = 2; cfg_t4 = 4;
  endtask

  task automatic t_busy_ignore();
    present(3'd3, 1'b0, 1'b1, 1'b1, 16'h5555);
    repeat (2) @(negedge clk);
    req_addr = 3'd6; req_wdata = 16'h0F0F; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_access();
    repeat (4) @(negedge clk);
    check_eq("R2 address held", addr_bad, 0);
    check_eq("R2 single strobe", stb_n, 3);
    check_eq("R2 single completion", done_n, 1);
    check_eq("R2 pins keep first address", dev_addr, 3);
    check_eq("R2 idle afterwards", busy, 0);
  endtask

  task automatic t_passthrough();
    @(negedge clk);
    dev_intrq = 1'b1; dev_reset_req = 1'b1;
    @(negedge clk);
    check_eq("R12 irq follows", irq_out, 1);
    check_eq("R12 reset asserted", dev_reset_n, 0);
    dev_intrq = 1'b0; dev_reset_req = 1'b0;
    @(negedge clk);
    check_eq("R12 irq clears", irq_out, 0);
    check_eq("R12 reset released", dev_reset_n, 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    chk_n++;
    fail_n++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    report();
    $finish;
  end

  initial begin
    rdy_lat = 0;
    stb_run = 0;
    exp_addr = '0;
    exp_dout = '0;
    clear_mon();
    t_reset();
    t_write_data();
    t_read_data();
    t_reg_read();
    t_reg_write();
    t_stretch();
    t_timeout();
    t_zero_counts();
    t_busy_ignore();
    t_passthrough();
    report();
    $finish;
  end

endmodule